// File: doc/BRIEF.md
# Self-Locking Fuse Configuration Register

This block is a single 32-bit configuration word meant to sit next to a one-time-programmable fuse controller. Software uses it to block reads and programming of fuse regions. The low half holds two lock bytes. Bits 7:0 are the read locks and bits 15:8 are the program locks. Bits 23:16 form a freeze byte. Setting freeze bit n protects read-lock bit n and program-lock bit n+8 from any later change. Bit 31 is a global fuse-off flag.

The freeze bits and the fuse-off flag can only be set. Once set they stay set until reset. So once software has committed a lock, it has no way to undo it. Software writes a whole word with one strobe. The full value reads back, and the two lock bytes and the fuse-off flag are also decoded onto their own ports for downstream logic.

Top module: `lockcfg_reg`

## Requirements
- R1: After reset the register reads 0x20000000, so `rd_lock`, `prog_lock` and `fuse_off` are all zero.
- R2: A write sets every bit of 23:16 that is 1 in the data. A bit of 23:16 that is already set stays set whatever is written.
- R3: Bit 31 (fuse-off) is set by writing 1 to it and is never cleared by a write.
- R4: While freeze bit 16+n is set, bits n and n+8 keep their value across any write.
- R5: Every bit in 15:0 whose freeze bit is clear takes the written value, so it can be set and cleared.
- R6: The freeze mask for a write comes from the register value before that write. A write that sets freeze bit 16+n still loads bits n and n+8 from its own data.
- R7: Bits 30:24, including bit 29 which is 1 after reset, are plain storage that takes the written value.
- R8: With `wr_en` low the register does not change.
- R9: `rd_data` is the whole register. `rd_lock` is bits 7:0, `prog_lock` is bits 15:8 and `fuse_off` is bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe; the word is updated at the next rising edge |
| wr_data | input | 32 | Value written |
| rd_data | output | 32 | Current register value |
| rd_lock | output | 8 | Read-lock byte (bits 7:0) |
| prog_lock | output | 8 | Program-lock byte (bits 15:8) |
| fuse_off | output | 1 | Global fuse-off flag (bit 31) |

## Verification
The bench writes all-ones and then all-zeros to the lock bytes with no freeze bit set. This shows that unlocked bits can be both set and cleared. Next, one write sets a freeze bit together with its lock bits, and a following write of zero tries to clear both. This separates a mask taken from the old value from one taken from the new value, and shows that frozen bits and freeze bits stay set. Writes of zero after the fuse-off flag and the upper storage bits are set show which bits are sticky and which are plain storage. Idle cycles carrying random data, then a long run of random writes, compare every cycle against a bit-by-bit model.

// File: rtl/lockcfg_reg.sv
module lockcfg_reg #(
  parameter logic [31:0] RESET_VALUE = 32'h2000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic [7:0]  rd_lock,
  output logic [7:0]  prog_lock,
  output logic        fuse_off
);

  logic [31:0] word_q;
  logic [31:0] word_d;
  logic [15:0] frz_mask;

  assign frz_mask = {word_q[23:16], word_q[23:16]};

  assign word_d = {word_q[31] | wr_data[31],
                   wr_data[30:24],
                   word_q[23:16] | wr_data[23:16],
                   (word_q[15:0] & frz_mask) | (wr_data[15:0] & ~frz_mask)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= RESET_VALUE;
    else if (wr_en) word_q <= word_d;
  end

  assign rd_data   = word_q;
  assign rd_lock   = word_q[7:0];
  assign prog_lock = word_q[15:8];
  assign fuse_off  = word_q[31];

  AST_FRZ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd_data[23:16] & $past(rd_data[23:16])) == $past(rd_data[23:16]))); // R2

  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_off |=> fuse_off); // R3

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((rd_data[15:0] ^ $past(rd_data[15:0])) &
               $past({rd_data[23:16], rd_data[23:16]})) == 16'h0)); // R4

  AST_OPEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data[15:0] & ~$past({rd_data[23:16], rd_data[23:16]})) ==
               ($past(wr_data[15:0]) & ~$past({rd_data[23:16], rd_data[23:16]})))); // R5

  AST_PLAIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[30:24] == $past(wr_data[30:24]))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R8

endmodule

// File: tb/lockcfg_reg_test.sv
module lockcfg_reg_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  rd_lock, prog_lock;
  logic        fuse_off;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] exp_w;

  lockcfg_reg uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
                   .rd_data(rd_data), .rd_lock(rd_lock), .prog_lock(prog_lock),
                   .fuse_off(fuse_off));

  always #2 clk = ~clk;

  function automatic logic [31:0] model(input logic [31:0] cur, input logic [31:0] d);
    logic [31:0] r = cur;
    for (int i = 0; i < 32; i++) begin
      if (i == 31 || (i >= 16 && i <= 23)) r[i] = cur[i] | d[i];
      else if (i < 16) begin
        if (!cur[16 + (i % 8)]) r[i] = d[i];
      end else r[i] = d[i];
    end
    return r;
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (rd_data !== exp_w) begin
      fails++;
      $display("FAIL %s: rd_data actual %h expected %h", tag, rd_data, exp_w);
    end
    checks++;
    if (rd_lock !== exp_w[7:0] || prog_lock !== exp_w[15:8] || fuse_off !== exp_w[31]) begin
      fails++;
      $display("FAIL R9: ports actual %h/%h/%b expected %h/%h/%b",
               rd_lock, prog_lock, fuse_off, exp_w[7:0], exp_w[15:8], exp_w[31]);
    end
  endtask

  // compare the result of the previous cycle, then drive this cycle
  task automatic step(input logic en, input logic [31:0] d, input string tag);
    @(negedge clk);
    compare(tag);
    wr_en = en;
    wr_data = d;
    if (en) exp_w = model(exp_w, d);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    exp_w = 32'h2000_0000;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    step(1, 32'h0000_FFFF, "R1");
    step(1, 32'h0000_0000, "R5");
    step(1, 32'h0001_0303, "R5");
    step(1, 32'h0000_0000, "R6");
    step(1, 32'h0000_FFFF, "R4");
    step(1, 32'h0000_0000, "R4");
    step(0, 32'hFFFF_FFFF, "R2");
    step(1, 32'h7F00_0000, "R8");
    step(1, 32'h0000_0000, "R7");
    step(1, 32'h8000_0000, "R7");
    step(1, 32'h0000_0000, "R3");
    for (int k = 0; k < 5; k++) step(0, $urandom, "R3");
    step(1, 32'h00F0_0000, "R8");
    step(1, 32'h0000_A5A5, "R2");
    step(1, 32'h0000_0000, "R4");
    for (int k = 0; k < 200; k++) step(k % 3 != 0, $urandom, "R5");
    step(0, 32'h0, "R4");
    finish_run();
  end
endmodule